// File: doc/BRIEF.md
# Sync-Aligned Sample Capture

This block takes a parallel sample stream and picks samples out of it at one of three rates: every clock, every second clock or every fourth clock. A single-cycle sync pulse sets the capture phase. Before the rate logic sees the sync pulse and the data word, both can be held back by zero, one or three clock cycles. The delay counts clock cycles, not samples. Each captured word comes out with a one-cycle valid strobe and a parity tag. The tag marks the sample captured on the sync cycle as even, and it alternates on each capture after that.

A terminal-count timer runs alongside the capture logic and takes the same delayed sync. It pulses its strobe eight clocks after the sync and then at a fixed period. The period is sixteen clocks times one more than a programmed count. The count is latched when the sync pulse arrives. A fresh sync restarts the capture phase, the parity tag and the timer together.

Top module: `sync_sample_capture`

## Requirements
- R1: Delay code 0 applies no delay to sync and data, code 1 applies one clock and code 2 applies three clocks. Code 3 acts as code 0. The delay acts on sync and data alike and comes before capture, so a sync sampled at edge E is acted on at edge E+d.
- R2: Rate code 0 selects full rate: after a sync, one sample is captured at every clock. Rate code 3 is reserved and also acts as full rate.
- R3: Rate code 1 selects half rate: captures happen at the sync edge and at every second edge after it.
- R4: Rate code 2 selects quarter rate: captures happen at the sync edge and at every fourth edge after it.
- R5: The capture made on the sync edge carries tag 0 (even). Each later capture inverts the tag, and tag 1 means odd.
- R6: The valid strobe is high for exactly one cycle for each capture. Between reset and the first sync, it stays low.
- R7: The terminal-count strobe is high for one cycle, eight clocks after the sync is acted on.
- R8: After the first pulse, the strobe repeats every 16*(C+1) clocks. C is the 8-bit count.
- R9: C is latched at each acted-on sync. Changing the count input during a period does not change the running period.
- R10: If a sync is acted on at the same edge where a terminal-count pulse is due, the sync wins. No pulse is issued, and the timer restarts its 8-clock lead.
- R11: Reset clears the delay stages, the counters and the outputs. It holds the valid strobe and the terminal-count strobe low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_in | input | 1 | Single-cycle sync pulse |
| din | input | DW | Input sample word |
| rate_sel | input | 2 | 0 full, 1 half, 2 quarter, 3 full |
| dly_sel | input | 2 | 0 none, 1 one clock, 2 three clocks, 3 none |
| period_cnt | input | CNT_W | Terminal-count period value C |
| smp_out | output | DW | Last captured sample |
| smp_odd | output | 1 | Parity tag of the last capture (1 = odd) |
| smp_vld | output | 1 | One-cycle strobe per capture |
| tc_out | output | 1 | Terminal-count strobe |

## Verification
Two events can land on the same edge: a sync that reaches the rate stage and a terminal-count pulse that the running period has made due. The bench places a second sync exactly 8 clocks after the first, which is where the first pulse would fall. It also places one at 24 clocks with a 16-clock period, which is where the second pulse would fall. The scoreboard then expects no strobe on that edge, a valid capture tagged even, and a new pulse 8 clocks later. A monitor compares every cycle against expected edge numbers that the bench works out from the delay, rate and period, so a strobe that comes early or late, or one that is missing or extra, counts as a mismatch.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

  typedef enum logic [1:0] {
    RATE_FULL    = 2'd0,
    RATE_HALF    = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_RSVD    = 2'd3
  } rate_e;

  typedef enum logic [1:0] {
    DLY_NONE  = 2'd0,
    DLY_ONE   = 2'd1,
    DLY_THREE = 2'd2,
    DLY_RSVD  = 2'd3
  } dly_e;

  // Clocks from an acted-on sync to the first terminal-count pulse.
  localparam int unsigned TC_LEAD = 8;
  // Longest selectable delay in clock cycles.
  localparam int unsigned DLY_MAX = 3;

  // Phase bits that must be zero for a capture in each rate.
  function automatic logic [1:0] rate_mask(input rate_e r);
    case (r)
      RATE_HALF:    rate_mask = 2'b01;
      RATE_QUARTER: rate_mask = 2'b11;
      default:      rate_mask = 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/cap_delay_line.sv
`timescale 1ns/1ps
module cap_delay_line
  import cap_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = DLY_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    dly_sel,
  output logic          sync_o,
  output logic [DW-1:0] data_o
);

  localparam int unsigned SW = DW + 1;

  logic [SW-1:0] stg_q [DEPTH];
  logic [SW-1:0] stg_d [DEPTH];
  logic [SW-1:0] tap;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_head
        always_comb stg_d[g] = {sync_i, data_i};
      end else begin : g_body
        always_comb stg_d[g] = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  always_comb begin
    case (dly_e'(dly_sel))
      DLY_ONE:   tap = stg_q[0];
      DLY_THREE: tap = stg_q[DEPTH-1];
      default:   tap = {sync_i, data_i};
    endcase
  end

  assign sync_o = tap[SW-1];
  assign data_o = tap[DW-1:0];

  // Cycles since reset, saturating, so that $past never reaches into reset.
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= '0;
    else if (age_q != 3'd7)   age_q <= age_q + 3'd1;
  end

  a_r1_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd1 && dly_sel == 2'd1) |-> {sync_o, data_o} == $past({sync_i, data_i}));

  a_r1_three_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd3 && dly_sel == 2'd2) |-> {sync_o, data_o} == $past({sync_i, data_i}, 3));

endmodule

// File: rtl/cap_rate_stage.sv
`timescale 1ns/1ps
module cap_rate_stage
  import cap_pkg::*;
#(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_i,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    rate_sel,
  output logic [DW-1:0] smp_o,
  output logic          odd_o,
  output logic          vld_o
);

  logic          armed_q, armed_d;
  logic [1:0]    phase_q, phase_d;
  logic [DW-1:0] smp_q,   smp_d;
  logic          odd_q,   odd_d;
  logic          vld_q,   vld_d;
  logic          take;

  // Next-state logic.
  always_comb begin
    take    = sync_i | (armed_q & ((phase_q & rate_mask(rate_e'(rate_sel))) == 2'b00));
    armed_d = armed_q | sync_i;
    phase_d = sync_i ? 2'd1 : phase_q + 2'd1;
    vld_d   = take;
    smp_d   = smp_q;
    odd_d   = odd_q;
    if (take) begin
      smp_d = data_i;
      odd_d = sync_i ? 1'b0 : ~odd_q;
    end
  end

  // State registers; clock enable on the sample word and tag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      phase_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      phase_q <= phase_d;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      odd_q <= 1'b0;
    end else if (take) begin
      smp_q <= smp_d;
      odd_q <= odd_d;
    end
  end

  assign smp_o = smp_q;
  assign odd_o = odd_q;
  assign vld_o = vld_q;

  a_r5_sync_even: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (vld_o && !odd_o));

  a_r6_idle_until_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !sync_i) |=> !vld_o);

  a_r2_full_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (rate_sel == 2'd0 || rate_sel == 2'd3)) |=> vld_o);

  a_r4_quarter_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && rate_sel == 2'd2 && !sync_i) |=> !vld_o);

  a_r3_half_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && rate_sel == 2'd1 && !sync_i) |=> !vld_o);

  a_r5_tag_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && armed_q && (rate_sel == 2'd0 || rate_sel == 2'd3) && !sync_i)
      |=> (odd_o != $past(odd_o)));

endmodule

// File: rtl/cap_tc_timer.sv
`timescale 1ns/1ps
module cap_tc_timer
  import cap_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             tc_o
);

  localparam int unsigned TW = CNT_W + 4;
  localparam int unsigned GW = CNT_W + 5;
  localparam logic [TW-1:0] LEAD_LOAD = TW'(TC_LEAD - 1);

  logic             run_q, run_d;
  logic [TW-1:0]    tmr_q, tmr_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             tc_q,  tc_d;

  always_comb begin
    run_d = run_q;
    tmr_d = tmr_q;
    per_d = per_q;
    tc_d  = 1'b0;
    if (sync_i) begin
      run_d = 1'b1;
      tmr_d = LEAD_LOAD;
      per_d = cnt_i;
    end else if (run_q) begin
      if (tmr_q == '0) begin
        tc_d  = 1'b1;
        tmr_d = {per_q, 4'hF};
      end else begin
        tmr_d = tmr_q - TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      tmr_q <= '0;
      per_q <= '0;
      tc_q  <= 1'b0;
    end else begin
      run_q <= run_d;
      tmr_q <= tmr_d;
      per_q <= per_d;
      tc_q  <= tc_d;
    end
  end

  assign tc_o = tc_q;

  // Checker state: clocks since sync, clocks since the last pulse.
  logic [3:0]    since_sync_q;
  logic          first_pend_q;
  logic [GW-1:0] gap_q;
  logic          had_tc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_sync_q <= '0;
      first_pend_q <= 1'b0;
      gap_q        <= '0;
      had_tc_q     <= 1'b0;
    end else begin
      if (sync_i)                    since_sync_q <= '0;
      else if (since_sync_q != 4'hF) since_sync_q <= since_sync_q + 4'd1;
      if (sync_i)    first_pend_q <= 1'b1;
      else if (tc_q) first_pend_q <= 1'b0;
      if (tc_q)                 gap_q <= GW'(1);
      else if (gap_q != '1)     gap_q <= gap_q + GW'(1);
      if (sync_i)    had_tc_q <= 1'b0;
      else if (tc_q) had_tc_q <= 1'b1;
    end
  end

  a_r7_first_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && first_pend_q) |-> since_sync_q == 4'(TC_LEAD));

  a_r8_period: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_o && had_tc_q) |-> gap_q == ({1'b0, per_q, 4'hF} + GW'(1)));

  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> !tc_o);

  a_r10_sync_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !tc_o);

endmodule

// File: rtl/sync_sample_capture.sv
`timescale 1ns/1ps
module sync_sample_capture
  import cap_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [DW-1:0]    din,
  input  logic [1:0]       rate_sel,
  input  logic [1:0]       dly_sel,
  input  logic [CNT_W-1:0] period_cnt,
  output logic [DW-1:0]    smp_out,
  output logic             smp_odd,
  output logic             smp_vld,
  output logic             tc_out
);

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          sync_dl;
  logic [DW-1:0] data_dl;

  cap_delay_line #(.DW(DW), .DEPTH(DLY_MAX)) u_dly (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sync_i  (sync_in),
    .data_i  (din),
    .dly_sel (dly_sel),
    .sync_o  (sync_dl),
    .data_o  (data_dl)
  );

  cap_rate_stage #(.DW(DW)) u_rate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .sync_i   (sync_dl),
    .data_i   (data_dl),
    .rate_sel (rate_sel),
    .smp_o    (smp_out),
    .odd_o    (smp_odd),
    .vld_o    (smp_vld)
  );

  cap_tc_timer #(.CNT_W(CNT_W)) u_tc (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sync_i (sync_dl),
    .cnt_i  (period_cnt),
    .tc_o   (tc_out)
  );

  a_r11_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |=> (!smp_vld && !tc_out) || !rst_int_n);

  a_r6_vld_tag_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !smp_vld |-> $stable(smp_odd));

endmodule

// File: tb/sim_sync_sample_capture.sv
`timescale 1ns/1ps
module sim_sync_sample_capture;

  localparam int DW    = 12;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sync_in = 1'b0;
  logic [DW-1:0]    din = '0;
  logic [1:0]       rate_sel = 2'd0;
  logic [1:0]       dly_sel = 2'd0;
  logic [CNT_W-1:0] period_cnt = '0;
  logic [DW-1:0]    smp_out;
  logic             smp_odd;
  logic             smp_vld;
  logic             tc_out;

  sync_sample_capture #(.DW(DW), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .din(din),
    .rate_sel(rate_sel), .dly_sel(dly_sel), .period_cnt(period_cnt),
    .smp_out(smp_out), .smp_odd(smp_odd), .smp_vld(smp_vld), .tc_out(tc_out)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct { int cyc; int data; bit odd; string rq; } cap_t;
  typedef struct { int cyc; string rq; } tc_t;

  cap_t capq[$];
  tc_t  tcq[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int dfun(int e);
    return (e * 29 + 60) % 4096;
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", rq, what, act, exp, cyc);
    end
  endtask

  // Data stream: the word sampled at edge E is dfun(E).
  initial forever begin
    @(negedge clk);
    din = DW'(dfun(cyc + 1));
  end

  // Monitor: compares each cycle against the scoreboard queues.
  initial forever begin
    @(posedge clk);
    #1;
    if (!rst_n) begin
      chk(!smp_vld && !tc_out && smp_out == '0 && !smp_odd, "R11", "reset outputs",
          {smp_vld, tc_out}, 0);
    end else begin
      bit exp_c;
      bit exp_t;
      exp_c = (capq.size() > 0) && (capq[0].cyc == cyc);
      exp_t = (tcq.size() > 0) && (tcq[0].cyc == cyc);
      chk(smp_vld == exp_c, exp_c ? capq[0].rq : "R6", "valid strobe", smp_vld, exp_c);
      if (exp_c) begin
        if (smp_vld) begin
          chk(int'(smp_out) == capq[0].data, capq[0].rq, "sample", smp_out, capq[0].data);
          chk(smp_odd == capq[0].odd, {capq[0].rq, " R5"}, "tag", smp_odd, capq[0].odd);
        end
        void'(capq.pop_front());
      end
      chk(tc_out == exp_t, exp_t ? tcq[0].rq : "R10", "terminal count", tc_out, exp_t);
      if (exp_t) void'(tcq.pop_front());
    end
  end

  // Driver: resets, sends a sync (optionally a second), pushes expectations.
  task automatic burst(int rate, int dly, int cnt, int cnt2, int chg_at,
                       int s2, int len, string rq);
    int d;
    int n;
    int e0;
    int t;
    int p;
    int cnt_s2;
    string rtag;
    @(negedge clk); rst_n = 1'b0; sync_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);   // no sync yet: R6 idle check via monitor
    d = (dly == 1) ? 1 : (dly == 2) ? 3 : 0;
    n = (rate == 1) ? 2 : (rate == 2) ? 4 : 1;
    rtag = (rate == 1) ? "R3" : (rate == 2) ? "R4" : "R2";
    rate_sel = 2'(rate); dly_sel = 2'(dly); period_cnt = CNT_W'(cnt);
    sync_in = 1'b1;
    e0 = cyc + 1;
    for (int j = 0; j <= len - 1 - d; j++) begin
      int base;
      base = (s2 > 0 && j >= s2) ? s2 : 0;
      if ((j - base) % n == 0)
        capq.push_back('{e0 + j + d, dfun(e0 + j), ((j - base) / n) % 2 == 1,
                         {rtag, " R1 ", rq}});
    end
    p = 16 * (cnt + 1);
    t = 8;
    while (t <= len - 1 - d && (s2 == 0 || t < s2)) begin
      tcq.push_back('{e0 + d + t, (t == 8) ? {"R7 ", rq} : {"R8 ", rq}});
      t += p;
    end
    if (s2 > 0) begin
      cnt_s2 = (chg_at > 0 && chg_at <= s2) ? cnt2 : cnt;
      p = 16 * (cnt_s2 + 1);
      t = s2 + 8;
      while (t <= len - 1 - d) begin
        tcq.push_back('{e0 + d + t, (t == s2 + 8) ? {"R7 ", rq} : {"R8 ", rq}});
        t += p;
      end
    end
    for (int j = 1; j < len; j++) begin
      @(negedge clk);
      if (j == chg_at) period_cnt = CNT_W'(cnt2);
      sync_in = (j == s2) ? 1'b1 : 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state (also checked every reset cycle by the monitor)
    chk(!smp_vld && !tc_out && smp_out == '0, "R11", "outputs in reset", smp_vld, 0);
    burst(0, 0, 0, 0, 0, 0, 60, "full no-delay");
    burst(1, 1, 1, 0, 0, 0, 80, "half one-clock");
    burst(2, 2, 0, 0, 0, 0, 70, "quarter three-clock");
    burst(3, 3, 0, 0, 0, 0, 40, "reserved codes");
    // R9: count changed mid-period has no effect on the running period
    burst(0, 0, 2, 0, 3, 0, 150, "R9 count held");
    // R9: a second sync latches the changed count
    burst(2, 1, 1, 0, 5, 13, 120, "R9 resync");
    // R10: sync on the edge of the first due pulse
    burst(1, 0, 0, 0, 0, 8, 80, "R10 first collision");
    // R10: sync on the edge of a repeat pulse
    burst(0, 2, 0, 0, 0, 24, 90, "R10 repeat collision");
    @(negedge clk); rst_n = 1'b0; sync_in = 1'b0;
    repeat (4) @(negedge clk);
    chk(capq.size() == 0, "R6", "captures left over", capq.size(), 0);
    chk(tcq.size() == 0, "R8", "pulses left over", tcq.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule